// File: doc/BRIEF.md
# Shadow Region Channel Access Masking

This block is the channel register file of a 64-channel DMA controller. It holds per-channel event flags, interrupt enables and interrupt pending flags, plus a narrow 4-bit event register for the quick-DMA channels. Software reaches them either through the unrestricted global view or through one of four region views.

Every region owns a 64-bit channel access mask, stored as a low word and a high word, and a 4-bit quick-channel mask. A region view sees a bit only where its mask holds a 1: masked bits read as zero and cannot be written. The same mask selects which channels drive that region's completion interrupt.

Several regions may share channels. A write made through one region is then visible through every other region whose mask covers the same bits. Only the global view can program the masks. Transfer engines report completions on per-channel set strobes, which raise the pending flags.

Top module: `shadow_mask_regfile`

## Requirements
- R1: Channel state is 64 bits wide per register kind, split into word addresses: 0 event low (channels 0-31), 1 event high (channels 32-63), 2 enable low, 3 enable high, 4 pending low, 5 pending high, 6 quick-channel events in bits 3:0.
- R2: After reset all masks are zero, every region-view read of addresses 0-6 returns 0, and every `irq` bit is 0.
- R3: A read through region r returns the register value in bit positions whose mask bit is 1, and 0 in the others. The mask is the low mask word for even addresses 0-4 and the high mask word for addresses 1-5.
- R4: A write through region r changes only the bits whose mask bit is 1. All other bits keep their value.
- R5: Reads and writes through the global view (`req_global`=1) are never masked.
- R6: Masks are reached only through the global view, with `req_region` selecting the region: address 8 is the low mask word, 9 the high word, 10 the quick mask in bits 3:0. A region-view read of addresses 8-10 returns 0, and a region-view write to them changes nothing.
- R7: The quick-channel register at address 6 is masked bitwise by the region's 4-bit quick mask. Its bits 31:4 always read 0.
- R8: `irq[r]` is the level OR over all 64 channels of pending AND enable AND region r's mask bit.
- R9: A 1 on `cmpl_set[n]` sets pending bit n at the next clock edge. The set wins over a bus write that clears the same bit in the same cycle.
- R10: Read data is presented on `rd_data` with `rd_valid` high exactly one cycle after a read request. Unmapped addresses read 0.
- R11: A write through one region is read back through another region in every bit where both masks are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_global | input | 1 | 1 = global view, 0 = region view |
| req_region | input | 2 | Region of the view, or target region of a mask access |
| req_addr | input | 4 | Word address |
| req_wdata | input | 32 | Write data |
| cmpl_set | input | 64 | Per-channel completion set strobes |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| irq | output | 4 | Per-region completion interrupt |

## Verification
A corrupted mask bit shows up in the next region-view read as a stray or missing 1. It also shows as an `irq` level that disagrees with pending and enable state within the same cycle. A write that ignores the mask shows up as a changed bit in a global read-back one cycle after the write. For that reason, every region-view write in the sweep is followed at once by a global read and by a read through the neighbouring region. A lost completion set is visible one cycle after the strobe, in both the pending word and the interrupt level.

// File: rtl/srm_pkg.sv
package srm_pkg;
  localparam int WORD_W = 32;

  localparam logic [3:0] A_EVT_LO = 4'd0;
  localparam logic [3:0] A_IEN_LO = 4'd2;
  localparam logic [3:0] A_PND_LO = 4'd4;
  localparam logic [3:0] A_QEVT   = 4'd6;
  localparam logic [3:0] A_MSK_LO = 4'd8;
  localparam logic [3:0] A_QMSK   = 4'd10;

  // Bits with a 1 in lanes take the new value; others keep the old one.
  function automatic logic [WORD_W-1:0] merge_masked(input logic [WORD_W-1:0] old_v,
                                                     input logic [WORD_W-1:0] new_v,
                                                     input logic [WORD_W-1:0] lanes);
    return (old_v & ~lanes) | (new_v & lanes);
  endfunction

  // Read view: positions outside lanes are forced to zero.
  function automatic logic [WORD_W-1:0] view_masked(input logic [WORD_W-1:0] val,
                                                    input logic [WORD_W-1:0] lanes);
    return val & lanes;
  endfunction
endpackage

// File: rtl/srm_mask_bank.sv
module srm_mask_bank import srm_pkg::*; #(
  parameter int NUM_REGION = 4,
  parameter int NUM_CH     = 64,
  parameter int NUM_QCH    = 4,
  parameter int RGN_W      = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [3:0]                   wr_addr,
  input  logic [RGN_W-1:0]             wr_region,
  input  logic [WORD_W-1:0]            wdata,
  output logic [NUM_REGION*NUM_CH-1:0]  mask_flat,
  output logic [NUM_REGION*NUM_QCH-1:0] qmask_flat
);
  localparam int NUM_WORD = NUM_CH / WORD_W;

  for (genvar r = 0; r < NUM_REGION; r++) begin : g_rgn
    logic hit;
    assign hit = wr_en && (wr_region == RGN_W'(r));

    for (genvar w = 0; w < NUM_WORD; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          mask_flat[r*NUM_CH + w*WORD_W +: WORD_W] <= '0;
        else if (hit && wr_addr == A_MSK_LO + 4'(w))
          mask_flat[r*NUM_CH + w*WORD_W +: WORD_W] <= wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        qmask_flat[r*NUM_QCH +: NUM_QCH] <= '0;
      else if (hit && wr_addr == A_QMSK)
        qmask_flat[r*NUM_QCH +: NUM_QCH] <= wdata[NUM_QCH-1:0];
    end
  end
endmodule

// File: rtl/srm_chan_regs.sv
module srm_chan_regs import srm_pkg::*; #(
  parameter int NUM_CH  = 64,
  parameter int NUM_QCH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [3:0]         wr_addr,
  input  logic [WORD_W-1:0]  wdata,
  input  logic [WORD_W-1:0]  lanes,
  input  logic [NUM_CH-1:0]  cmpl_set,
  output logic [NUM_CH-1:0]  evt_q,
  output logic [NUM_CH-1:0]  ien_q,
  output logic [NUM_CH-1:0]  ipend_q,
  output logic [NUM_QCH-1:0] qevt_q
);
  localparam int NUM_WORD = NUM_CH / WORD_W;

  for (genvar w = 0; w < NUM_WORD; w++) begin : g_word
    localparam int LO = w*WORD_W;
    logic wr_evt, wr_ien, wr_pnd;
    logic [WORD_W-1:0] pnd_base;

    assign wr_evt = wr_en && wr_addr == A_EVT_LO + 4'(w);
    assign wr_ien = wr_en && wr_addr == A_IEN_LO + 4'(w);
    assign wr_pnd = wr_en && wr_addr == A_PND_LO + 4'(w);
    assign pnd_base = wr_pnd ? merge_masked(ipend_q[LO +: WORD_W], wdata, lanes)
                             : ipend_q[LO +: WORD_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        evt_q[LO +: WORD_W]   <= '0;
        ien_q[LO +: WORD_W]   <= '0;
        ipend_q[LO +: WORD_W] <= '0;
      end else begin
        if (wr_evt) evt_q[LO +: WORD_W] <= merge_masked(evt_q[LO +: WORD_W], wdata, lanes);
        if (wr_ien) ien_q[LO +: WORD_W] <= merge_masked(ien_q[LO +: WORD_W], wdata, lanes);
        // completion strobes win over a same-cycle clearing write
        ipend_q[LO +: WORD_W] <= pnd_base | cmpl_set[LO +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      qevt_q <= '0;
    else if (wr_en && wr_addr == A_QEVT)
      qevt_q <= (qevt_q & ~lanes[NUM_QCH-1:0]) | (wdata[NUM_QCH-1:0] & lanes[NUM_QCH-1:0]);
  end
endmodule

// File: rtl/srm_irq_reduce.sv
module srm_irq_reduce #(
  parameter int NUM_REGION = 4,
  parameter int NUM_CH     = 64
) (
  input  logic [NUM_CH-1:0]            ipend,
  input  logic [NUM_CH-1:0]            ien,
  input  logic [NUM_REGION*NUM_CH-1:0] mask_flat,
  output logic [NUM_REGION-1:0]        irq
);
  for (genvar r = 0; r < NUM_REGION; r++) begin : g_rgn
    assign irq[r] = |(ipend & ien & mask_flat[r*NUM_CH +: NUM_CH]);
  end
endmodule

// File: rtl/shadow_mask_regfile.sv
module shadow_mask_regfile import srm_pkg::*; #(
  parameter int NUM_REGION = 4,
  parameter int NUM_CH     = 64,
  parameter int NUM_QCH    = 4,
  localparam int RGN_W     = $clog2(NUM_REGION)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic                  req_global,
  input  logic [RGN_W-1:0]      req_region,
  input  logic [3:0]            req_addr,
  input  logic [WORD_W-1:0]     req_wdata,
  input  logic [NUM_CH-1:0]     cmpl_set,
  output logic                  rd_valid,
  output logic [WORD_W-1:0]     rd_data,
  output logic [NUM_REGION-1:0] irq
);
  // named internal events
  logic                          is_chan, is_mask;
  logic                          chan_wr, mask_wr, acc_rd;
  logic [WORD_W-1:0]             lane_mask, raw_word;
  logic [WORD_W-1:0]             rgn_lo, rgn_hi;
  logic [NUM_QCH-1:0]            rgn_q;
  logic [NUM_REGION*NUM_CH-1:0]  mask_flat;
  logic [NUM_REGION*NUM_QCH-1:0] qmask_flat;
  logic [NUM_CH-1:0]             evt_q, ien_q, ipend_q;
  logic [NUM_QCH-1:0]            qevt_q;

  assign is_chan = req_addr <= A_QEVT;
  assign is_mask = req_addr >= A_MSK_LO && req_addr <= A_QMSK;
  assign chan_wr = req_valid && req_write && is_chan;
  assign mask_wr = req_valid && req_write && req_global && is_mask;
  assign acc_rd  = req_valid && !req_write;

  assign rgn_lo = mask_flat[req_region*NUM_CH +: WORD_W];
  assign rgn_hi = mask_flat[req_region*NUM_CH + WORD_W +: WORD_W];
  assign rgn_q  = qmask_flat[req_region*NUM_QCH +: NUM_QCH];

  always_comb begin
    if (req_global)                lane_mask = '1;
    else if (req_addr == A_QEVT)   lane_mask = WORD_W'(rgn_q);
    else if (is_chan)              lane_mask = req_addr[0] ? rgn_hi : rgn_lo;
    else                           lane_mask = '0;
  end

  always_comb begin
    raw_word = '0;
    if (req_addr == A_QEVT) begin
      raw_word = WORD_W'(qevt_q);
    end else if (is_chan) begin
      case (req_addr[2:1])
        2'd0:    raw_word = evt_q[req_addr[0]*WORD_W +: WORD_W];
        2'd1:    raw_word = ien_q[req_addr[0]*WORD_W +: WORD_W];
        default: raw_word = ipend_q[req_addr[0]*WORD_W +: WORD_W];
      endcase
    end else if (req_addr == A_QMSK) begin
      raw_word = WORD_W'(rgn_q);
    end else if (is_mask) begin
      raw_word = req_addr[0] ? rgn_hi : rgn_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= acc_rd;
      if (acc_rd) rd_data <= view_masked(raw_word, lane_mask);
    end
  end

  srm_mask_bank #(.NUM_REGION(NUM_REGION), .NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH), .RGN_W(RGN_W)) mask_i (
    .clk(clk), .rst_n(rst_n), .wr_en(mask_wr), .wr_addr(req_addr), .wr_region(req_region),
    .wdata(req_wdata), .mask_flat(mask_flat), .qmask_flat(qmask_flat));

  srm_chan_regs #(.NUM_CH(NUM_CH), .NUM_QCH(NUM_QCH)) chan_i (
    .clk(clk), .rst_n(rst_n), .wr_en(chan_wr), .wr_addr(req_addr), .wdata(req_wdata),
    .lanes(lane_mask), .cmpl_set(cmpl_set), .evt_q(evt_q), .ien_q(ien_q),
    .ipend_q(ipend_q), .qevt_q(qevt_q));

  srm_irq_reduce #(.NUM_REGION(NUM_REGION), .NUM_CH(NUM_CH)) irq_i (
    .ipend(ipend_q), .ien(ien_q), .mask_flat(mask_flat), .irq(irq));
endmodule

// File: rtl/srm_checker.sv
module srm_checker #(
  parameter int NUM_REGION = 4,
  parameter int NUM_CH     = 64,
  parameter int RGN_W      = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         req_write,
  input logic                         req_global,
  input logic [3:0]                   req_addr,
  input logic [NUM_CH-1:0]            cmpl_set,
  input logic                         rd_valid,
  input logic [31:0]                  rd_data,
  input logic [NUM_REGION-1:0]        irq,
  input logic                         chan_wr,
  input logic [31:0]                  lane_mask,
  input logic [NUM_REGION*NUM_CH-1:0] mask_flat,
  input logic [NUM_CH-1:0]            evt_q,
  input logic [NUM_CH-1:0]            ien_q,
  input logic [NUM_CH-1:0]            ipend_q
);
  AST_REGION_READ_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(req_valid && !req_write && !req_global)) |-> ((rd_data & ~$past(lane_mask)) == 32'd0)); // R3

  AST_REGION_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(chan_wr && !req_global && req_addr == 4'd0) |->
      ((evt_q[31:0] & ~$past(lane_mask)) == ($past(evt_q[31:0]) & ~$past(lane_mask)))); // R4

  AST_MASK_REGION_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_write && !req_global) |-> (mask_flat == $past(mask_flat))); // R6

  AST_COMPLETION_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(|cmpl_set) |-> (($past(cmpl_set) & ~ipend_q) == '0)); // R9

  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_write) |-> rd_valid); // R10

  for (genvar r = 0; r < NUM_REGION; r++) begin : g_irq
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq[r] |-> ((ipend_q & ien_q) != '0)); // R8
  end
endmodule

bind shadow_mask_regfile srm_checker #(.NUM_REGION(NUM_REGION), .NUM_CH(NUM_CH), .RGN_W(RGN_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_global(req_global), .req_addr(req_addr), .cmpl_set(cmpl_set),
  .rd_valid(rd_valid), .rd_data(rd_data), .irq(irq), .chan_wr(chan_wr),
  .lane_mask(lane_mask), .mask_flat(mask_flat), .evt_q(evt_q), .ien_q(ien_q),
  .ipend_q(ipend_q));

// File: tb/shadow_mask_regfile_tb_top.sv
`timescale 1ns/1ps
module shadow_mask_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_global = 1'b0;
  logic [1:0]  req_region = '0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [63:0] cmpl_set = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [3:0]  irq;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // bench model of the register state
  logic [63:0] m_evt = '0, m_ien = '0, m_pnd = '0;
  logic [3:0]  m_q = '0;
  logic [63:0] m_msk [4];
  logic [3:0]  m_qm  [4];

  always #4 clk = ~clk;

  shadow_mask_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_global(req_global), .req_region(req_region), .req_addr(req_addr),
    .req_wdata(req_wdata), .cmpl_set(cmpl_set), .rd_valid(rd_valid),
    .rd_data(rd_data), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lanes_of(input bit g, input int r, input int a);
    if (g) return 32'hFFFF_FFFF;
    if (a == 6) return {28'd0, m_qm[r]};
    if (a < 6) return a[0] ? m_msk[r][63:32] : m_msk[r][31:0];
    return 32'd0;
  endfunction

  function automatic logic [31:0] raw_of(input int r, input int a);
    case (a)
      0: return m_evt[31:0];
      1: return m_evt[63:32];
      2: return m_ien[31:0];
      3: return m_ien[63:32];
      4: return m_pnd[31:0];
      5: return m_pnd[63:32];
      6: return {28'd0, m_q};
      8: return m_msk[r][31:0];
      9: return m_msk[r][63:32];
      10: return {28'd0, m_qm[r]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] v;
    for (int r = 0; r < 4; r++) v[r] = |(m_pnd & m_ien & m_msk[r]);
    return v;
  endfunction

  task automatic model_write(input bit g, input int r, input int a, input logic [31:0] d);
    logic [31:0] ln, nv;
    ln = lanes_of(g, r, a);
    nv = (raw_of(r, a) & ~ln) | (d & ln);
    case (a)
      0: m_evt[31:0] = nv;
      1: m_evt[63:32] = nv;
      2: m_ien[31:0] = nv;
      3: m_ien[63:32] = nv;
      4: m_pnd[31:0] = nv;
      5: m_pnd[63:32] = nv;
      6: m_q = nv[3:0];
      8: if (g) m_msk[r][31:0] = d;
      9: if (g) m_msk[r][63:32] = d;
      10: if (g) m_qm[r] = d[3:0];
      default: ;
    endcase
  endtask

  task automatic bus_wr(input bit g, input int r, input int a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_global = g;
    req_region = 2'(r); req_addr = 4'(a); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    model_write(g, r, a, d);
  endtask

  task automatic bus_rd(input bit g, input int r, input int a, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_global = g;
    req_region = 2'(r); req_addr = 4'(a);
    @(negedge clk);
    req_valid = 1'b0;
    chk(tag, rd_data, raw_of(r, a) & lanes_of(g, r, a));
  endtask

  task automatic pulse_cmpl(input logic [63:0] s);
    @(negedge clk);
    cmpl_set = s;
    @(negedge clk);
    cmpl_set = '0;
    m_pnd = m_pnd | s;
  endtask

  initial begin
    for (int r = 0; r < 4; r++) begin m_msk[r] = '0; m_qm[r] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state, nothing visible through any region
    chk("R2 irq", {28'd0, irq}, 32'd0);
    for (int r = 0; r < 4; r++)
      for (int a = 0; a < 7; a++) bus_rd(1'b0, r, a, "R2 region read");
    bus_rd(1'b1, 2, 8, "R2 mask reset");

    // R1/R5: global writes land unmasked in the addressed word
    bus_wr(1'b1, 0, 1, 32'hDEAD_BEEF);
    bus_rd(1'b1, 0, 1, "R1 event high word");
    bus_rd(1'b1, 0, 0, "R1 event low word untouched");
    for (int a = 0; a < 7; a++) bus_wr(1'b1, 0, a, 32'h5A5A_C3C3 ^ (32'h0101_0101 * a));
    for (int a = 0; a < 7; a++) bus_rd(1'b1, 0, a, "R5 global view");

    // R6: program masks through the global view, neighbours overlap
    for (int r = 0; r < 4; r++) begin
      bus_wr(1'b1, r, 8, 32'h0F0F_F0F0 ^ (32'h1111_1111 << r));
      bus_wr(1'b1, r, 9, 32'hFFFF_0000 >> (r * 8));
      bus_wr(1'b1, r, 10, 32'(4'b0011 << (r % 3)));
    end
    for (int r = 0; r < 4; r++)
      for (int a = 8; a < 11; a++) bus_rd(1'b1, r, a, "R6 mask read-back");
    bus_wr(1'b0, 1, 8, 32'hFFFF_FFFF);
    bus_wr(1'b0, 1, 10, 32'h0000_000F);
    bus_rd(1'b1, 1, 8, "R6 region write to mask ignored");
    bus_rd(1'b1, 1, 10, "R6 region write to quick mask ignored");
    bus_rd(1'b0, 1, 9, "R6 region read of mask is zero");

    // R3/R4/R7/R11: sweep every region over every channel word
    for (int r = 0; r < 4; r++)
      for (int a = 0; a < 7; a++) begin
        bus_rd(1'b0, r, a, (a == 6) ? "R7 quick read masked" : "R3 region read masked");
        bus_wr(1'b0, r, a, 32'h9E37_79B9 * (r * 8 + a + 1));
        bus_rd(1'b1, 0, a, (a == 6) ? "R7 quick write masked" : "R4 region write masked");
        bus_rd(1'b0, (r + 1) % 4, a, "R11 shared bits seen by other region");
      end

    // R10: unmapped address and valid timing
    bus_rd(1'b1, 0, 12, "R10 unmapped reads zero");
    bus_rd(1'b0, 3, 15, "R10 unmapped region read zero");
    @(negedge clk);
    chk("R10 valid low when idle", {31'd0, rd_valid}, 32'd0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_global = 1'b1; req_addr = 4'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 valid one cycle after read", {31'd0, rd_valid}, 32'd1);

    // R8/R9: interrupt levels from completion strobes
    bus_wr(1'b1, 0, 2, 32'hFFFF_FFFF);
    bus_wr(1'b1, 0, 3, 32'hFFFF_FFFF);
    bus_wr(1'b1, 0, 4, 32'd0);
    bus_wr(1'b1, 0, 5, 32'd0);
    chk("R8 no pending no irq", {28'd0, irq}, 32'd0);
    foreach (m_msk[i]) ;
    begin
      int chs [6] = '{0, 5, 31, 32, 47, 63};
      foreach (chs[k]) begin
        bus_wr(1'b1, 0, 4, 32'd0);
        bus_wr(1'b1, 0, 5, 32'd0);
        pulse_cmpl(64'd1 << chs[k]);
        chk("R8 irq per channel", {28'd0, irq}, {28'd0, exp_irq()});
        bus_rd(1'b1, 0, chs[k] < 32 ? 4 : 5, "R9 completion sets pending");
      end
    end
    pulse_cmpl(64'hFFFF_FFFF_FFFF_FFFF);
    chk("R8 all pending", {28'd0, irq}, {28'd0, exp_irq()});
    bus_wr(1'b1, 0, 2, 32'd0);
    bus_wr(1'b1, 0, 3, 32'hFFFF_FFFE);
    chk("R8 enable gates irq", {28'd0, irq}, {28'd0, exp_irq()});
    bus_wr(1'b1, 2, 8, 32'd0);
    bus_wr(1'b1, 2, 9, 32'd0);
    chk("R8 zero mask silences region", {31'd0, irq[2]}, 32'd0);
    chk("R8 other regions after mask clear", {28'd0, irq}, {28'd0, exp_irq()});

    // R9: set beats a same-cycle clearing write
    bus_wr(1'b1, 0, 4, 32'hFFFF_FFFF);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_global = 1'b1; req_addr = 4'd4;
    req_wdata = 32'd0; cmpl_set = 64'd1 << 3;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; cmpl_set = '0;
    m_pnd[31:0] = 32'h0000_0008;
    bus_rd(1'b1, 0, 4, "R9 set wins over clear");

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule